// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is the hardwired control unit of a small accumulator machine with four instructions. Each instruction word holds a two-bit operation code above a fourteen-bit operand address. The sequencer steps through instruction fetch, a single decode step and one of four execute sequences: load, store, add, and branch when the accumulator is negative. It talks to memory over a four-phase handshake built from a Request line, a Read/Write line and a Wait line from memory. Wait high means memory is ready or still busy with a request. Wait falling means the request has completed.

The control outputs are Mealy outputs. Each strobe is a combinational function of the current state, the synchronized Wait, the operation code and the accumulator sign. A strobe is therefore high during the cycle whose closing clock edge performs the transfer. Any strobe that a transition does not name is held low. The Wait input passes through a flop synchronizer inside the block. Reset is expected to arrive already synchronized, and it drives the PC-clear strobe directly.

Top module: `accum_seq_ctrl`

## Requirements
- R1: While `rst_sync` is high, `pc_clr` is high and every other output is low, in the same cycle, whatever the state. The next state is the reset state.
- R2: In the first cycle after reset is released, `pc_inc`, `pc_to_abus` and `abus_to_mar` are high together. Every other output is low.
- R3: A change on `mem_wait` reaches the control logic after exactly two rising clock edges.
- R4: In the fetch-idle state, no output is high while synchronized Wait is low. Once it is high, `mem_req`, `mem_rd` and `mar_to_mem` are driven high.
- R5: During a read, `mem_req`, `mem_rd` and `mar_to_mem` stay high while synchronized Wait is high. When Wait is seen low, the outputs show `mem_to_mbr` alone for one cycle, with `mem_req` low.
- R6: After an instruction has been captured, no output is high until synchronized Wait returns high. In that cycle `mbr_to_ir` alone is high.
- R7: Decode uses the opcode value 00 for load, 01 for store, 10 for add and 11 for branch-negative. Load and add assert `irad_to_mar` alone. Store asserts `irad_to_mar` and `ac_to_mbr`.
- R8: A load runs a read with no initial wait. After the data cycle, the next cycle shows `ac_load` with `alu_add` low (pass B), together with the three fetch strobes of R2.
- R9: An add behaves like a load, except that the final cycle has `alu_add` high.
- R10: A store drives `mem_req`, `mar_to_mem` and `mbr_to_mem` with `mem_rd` low until synchronized Wait is seen low. In that cycle it shows the three fetch strobes, with no extra wait state.
- R11: At decode, a branch asserts `irad_to_pc` exactly when `ac_sign` is 1. The cycle after that shows the three fetch strobes.
- R12: `mem_rd` is never high unless `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_sync | input | 1 | Synchronized active-high reset |
| mem_wait | input | 1 | Memory Wait line, asynchronous |
| opcode | input | 2 | Instruction register bits 15:14 |
| ac_sign | input | 1 | Accumulator bit 15 |
| pc_clr | output | 1 | Clear PC |
| pc_inc | output | 1 | Increment PC |
| pc_to_abus | output | 1 | Gate PC onto address bus |
| abus_to_mar | output | 1 | Load MAR from address bus |
| irad_to_mar | output | 1 | Load MAR from IR address field |
| mar_to_mem | output | 1 | Gate MAR onto memory address bus |
| mbr_to_mem | output | 1 | Gate MBR onto memory data bus |
| mem_to_mbr | output | 1 | Load MBR from memory data bus |
| mbr_to_ir | output | 1 | Load IR from MBR |
| ac_to_mbr | output | 1 | Load MBR from AC |
| alu_add | output | 1 | ALU select: 1 add, 0 pass B |
| ac_load | output | 1 | Load AC from ALU result |
| irad_to_pc | output | 1 | Load PC from IR address field |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | Memory direction: 1 read, 0 write |

## Verification
A wrong state shows at the ports in the same cycle, because the strobes depend on the state without any register in between. If the sequencer skips a state or lingers in one, the full strobe vector for that cycle differs from the expected vector at once. The same is true for a wrong decode branch, a dropped handshake hold or a missing fetch action. A synchronizer with the wrong depth moves the capture cycle by one clock relative to the Wait edge. The bench drives each scenario cycle by cycle and compares every output on every cycle.

// File: rtl/accum_ctrl_pkg.sv
package accum_ctrl_pkg;

    localparam int OPC_W = 2;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 2'b00;
    localparam logic [OPC_W-1:0] OPC_STORE = 2'b01;
    localparam logic [OPC_W-1:0] OPC_ADD   = 2'b10;
    localparam logic [OPC_W-1:0] OPC_BRNEG = 2'b11;

    typedef enum logic [3:0] {
        S_RES,
        S_IF0,
        S_IF1,
        S_IF2,
        S_DEC,
        S_LD0,
        S_LD1,
        S_LD2,
        S_ST0,
        S_ST1,
        S_AD0,
        S_AD1,
        S_AD2,
        S_BR0
    } seq_state_e;

    typedef struct packed {
        logic pc_clr;
        logic pc_inc;
        logic pc_to_abus;
        logic abus_to_mar;
        logic irad_to_mar;
        logic mar_to_mem;
        logic mbr_to_mem;
        logic mem_to_mbr;
        logic mbr_to_ir;
        logic ac_to_mbr;
        logic alu_add;
        logic ac_load;
        logic irad_to_pc;
        logic mem_req;
        logic mem_rd;
    } uop_t;

endpackage

// File: rtl/accum_wait_sync.sv
module accum_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/accum_seq_next.sv
module accum_seq_next
    import accum_ctrl_pkg::*;
(
    input  seq_state_e       state_q,
    input  logic             rst_sync,
    input  logic             wait_s,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ac_sign,
    output seq_state_e       state_d,
    output uop_t             uop
);

    always_comb begin
        uop     = '0;
        state_d = state_q;
        if (rst_sync) begin
            uop.pc_clr = 1'b1;
            state_d    = S_RES;
        end else begin
            unique case (state_q)
                S_RES, S_BR0: begin
                    uop.pc_inc      = 1'b1;
                    uop.pc_to_abus  = 1'b1;
                    uop.abus_to_mar = 1'b1;
                    state_d         = S_IF0;
                end
                S_IF0: begin
                    if (wait_s) begin
                        uop.mar_to_mem = 1'b1;
                        uop.mem_req    = 1'b1;
                        uop.mem_rd     = 1'b1;
                        state_d        = S_IF1;
                    end
                end
                S_LD0, S_AD0: begin
                    uop.mar_to_mem = 1'b1;
                    uop.mem_req    = 1'b1;
                    uop.mem_rd     = 1'b1;
                    state_d        = (state_q == S_LD0) ? S_LD1 : S_AD1;
                end
                S_IF1, S_LD1, S_AD1: begin
                    if (wait_s) begin
                        uop.mar_to_mem = 1'b1;
                        uop.mem_req    = 1'b1;
                        uop.mem_rd     = 1'b1;
                    end else begin
                        uop.mem_to_mbr = 1'b1;
                        state_d        = (state_q == S_IF1) ? S_IF2 :
                                         (state_q == S_LD1) ? S_LD2 : S_AD2;
                    end
                end
                S_IF2: begin
                    if (wait_s) begin
                        uop.mbr_to_ir = 1'b1;
                        state_d       = S_DEC;
                    end
                end
                S_DEC: begin
                    unique case (opcode)
                        OPC_LOAD: begin
                            uop.irad_to_mar = 1'b1;
                            state_d         = S_LD0;
                        end
                        OPC_STORE: begin
                            uop.irad_to_mar = 1'b1;
                            uop.ac_to_mbr   = 1'b1;
                            state_d         = S_ST0;
                        end
                        OPC_ADD: begin
                            uop.irad_to_mar = 1'b1;
                            state_d         = S_AD0;
                        end
                        OPC_BRNEG: begin
                            uop.irad_to_pc = ac_sign;
                            state_d        = S_BR0;
                        end
                        default: state_d = S_RES;
                    endcase
                end
                S_LD2, S_AD2: begin
                    uop.ac_load     = 1'b1;
                    uop.alu_add     = (state_q == S_AD2);
                    uop.pc_inc      = 1'b1;
                    uop.pc_to_abus  = 1'b1;
                    uop.abus_to_mar = 1'b1;
                    state_d         = S_IF0;
                end
                S_ST0: begin
                    uop.mar_to_mem = 1'b1;
                    uop.mbr_to_mem = 1'b1;
                    uop.mem_req    = 1'b1;
                    state_d        = S_ST1;
                end
                S_ST1: begin
                    if (wait_s) begin
                        uop.mar_to_mem = 1'b1;
                        uop.mbr_to_mem = 1'b1;
                        uop.mem_req    = 1'b1;
                    end else begin
                        uop.pc_inc      = 1'b1;
                        uop.pc_to_abus  = 1'b1;
                        uop.abus_to_mar = 1'b1;
                        state_d         = S_IF0;
                    end
                end
                default: state_d = S_RES;
            endcase
        end
    end

endmodule

// File: rtl/accum_seq_ctrl.sv
module accum_seq_ctrl
    import accum_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_sync,
    input  logic             mem_wait,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ac_sign,
    output logic             pc_clr,
    output logic             pc_inc,
    output logic             pc_to_abus,
    output logic             abus_to_mar,
    output logic             irad_to_mar,
    output logic             mar_to_mem,
    output logic             mbr_to_mem,
    output logic             mem_to_mbr,
    output logic             mbr_to_ir,
    output logic             ac_to_mbr,
    output logic             alu_add,
    output logic             ac_load,
    output logic             irad_to_pc,
    output logic             mem_req,
    output logic             mem_rd
);

    seq_state_e state_d;
    seq_state_e state_q;
    logic       wait_s;
    uop_t       uop;

    accum_wait_sync #(
        .STAGES(SYNC_STAGES)
    ) u_wait_sync (
        .clk  (clk),
        .din  (mem_wait),
        .dout (wait_s)
    );

    accum_seq_next u_next (
        .state_q  (state_q),
        .rst_sync (rst_sync),
        .wait_s   (wait_s),
        .opcode   (opcode),
        .ac_sign  (ac_sign),
        .state_d  (state_d),
        .uop      (uop)
    );

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_clr      = uop.pc_clr;
    assign pc_inc      = uop.pc_inc;
    assign pc_to_abus  = uop.pc_to_abus;
    assign abus_to_mar = uop.abus_to_mar;
    assign irad_to_mar = uop.irad_to_mar;
    assign mar_to_mem  = uop.mar_to_mem;
    assign mbr_to_mem  = uop.mbr_to_mem;
    assign mem_to_mbr  = uop.mem_to_mbr;
    assign mbr_to_ir   = uop.mbr_to_ir;
    assign ac_to_mbr   = uop.ac_to_mbr;
    assign alu_add     = uop.alu_add;
    assign ac_load     = uop.ac_load;
    assign irad_to_pc  = uop.irad_to_pc;
    assign mem_req     = uop.mem_req;
    assign mem_rd      = uop.mem_rd;

endmodule

// File: rtl/accum_seq_ctrl_chk.sv
module accum_seq_ctrl_chk (
    input logic clk,
    input logic rst_sync,
    input logic pc_inc,
    input logic pc_to_abus,
    input logic abus_to_mar,
    input logic irad_to_mar,
    input logic mem_to_mbr,
    input logic ac_load,
    input logic irad_to_pc,
    input logic mem_req,
    input logic mem_rd
);

    // R2
    release_fetch_chk: assert property (@(posedge clk) disable iff (rst_sync)
        $fell(rst_sync) |-> (pc_inc && pc_to_abus && abus_to_mar));

    // R5
    read_hold_chk: assert property (@(posedge clk) disable iff (rst_sync)
        (mem_req && mem_rd) |=> (mem_req || mem_to_mbr));

    // R5
    capture_no_req_chk: assert property (@(posedge clk) disable iff (rst_sync)
        mem_to_mbr |=> !mem_req);

    // R7
    operand_read_chk: assert property (@(posedge clk) disable iff (rst_sync)
        irad_to_mar |=> mem_req);

    // R8
    ac_load_fetch_chk: assert property (@(posedge clk) disable iff (rst_sync)
        ac_load |-> (pc_inc && abus_to_mar));

    // R10
    write_hold_chk: assert property (@(posedge clk) disable iff (rst_sync)
        (mem_req && !mem_rd) |=> ((mem_req && !mem_rd) || pc_inc));

    // R11
    branch_then_fetch_chk: assert property (@(posedge clk) disable iff (rst_sync)
        irad_to_pc |=> pc_inc);

    // R12
    rd_needs_req_chk: assert property (@(posedge clk) disable iff (rst_sync)
        mem_rd |-> mem_req);

endmodule

bind accum_seq_ctrl accum_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_sync    (rst_sync),
    .pc_inc      (pc_inc),
    .pc_to_abus  (pc_to_abus),
    .abus_to_mar (abus_to_mar),
    .irad_to_mar (irad_to_mar),
    .mem_to_mbr  (mem_to_mbr),
    .ac_load     (ac_load),
    .irad_to_pc  (irad_to_pc),
    .mem_req     (mem_req),
    .mem_rd      (mem_rd)
);

// File: tb/accum_seq_ctrl_bench.sv
`timescale 1ns/1ps
module accum_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_sync = 1'b1;
    logic       mem_wait = 1'b1;
    logic [1:0] opcode = 2'b00;
    logic       ac_sign = 1'b0;
    logic pc_clr, pc_inc, pc_to_abus, abus_to_mar, irad_to_mar, mar_to_mem;
    logic mbr_to_mem, mem_to_mbr, mbr_to_ir, ac_to_mbr, alu_add, ac_load;
    logic irad_to_pc, mem_req, mem_rd;
    logic [14:0] outv;

    int tests = 0;
    int fails = 0;

    // bit 14 pc_clr .. bit 0 mem_rd, in port order
    localparam logic [14:0] P_NONE  = 15'h0000;
    localparam logic [14:0] P_CLR   = 15'h4000;
    localparam logic [14:0] P_FETCH = 15'h3800;
    localparam logic [14:0] P_RDREQ = 15'h0203;
    localparam logic [14:0] P_WRREQ = 15'h0302;
    localparam logic [14:0] P_CAPT  = 15'h0080;
    localparam logic [14:0] P_TOIR  = 15'h0040;
    localparam logic [14:0] P_DECLA = 15'h0400;
    localparam logic [14:0] P_DECST = 15'h0420;
    localparam logic [14:0] P_BRT   = 15'h0004;
    localparam logic [14:0] P_LDEND = 15'h3808;
    localparam logic [14:0] P_ADEND = 15'h3818;

    always #10 clk = ~clk;

    accum_seq_ctrl u_accum_seq_ctrl (
        .clk(clk), .rst_sync(rst_sync), .mem_wait(mem_wait), .opcode(opcode),
        .ac_sign(ac_sign), .pc_clr(pc_clr), .pc_inc(pc_inc),
        .pc_to_abus(pc_to_abus), .abus_to_mar(abus_to_mar),
        .irad_to_mar(irad_to_mar), .mar_to_mem(mar_to_mem),
        .mbr_to_mem(mbr_to_mem), .mem_to_mbr(mem_to_mbr),
        .mbr_to_ir(mbr_to_ir), .ac_to_mbr(ac_to_mbr), .alu_add(alu_add),
        .ac_load(ac_load), .irad_to_pc(irad_to_pc), .mem_req(mem_req),
        .mem_rd(mem_rd)
    );

    assign outv = {pc_clr, pc_inc, pc_to_abus, abus_to_mar, irad_to_mar,
                   mar_to_mem, mbr_to_mem, mem_to_mbr, mbr_to_ir, ac_to_mbr,
                   alu_add, ac_load, irad_to_pc, mem_req, mem_rd};

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [14:0] exp);
        tests++;
        if (outv !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, outv, exp);
        end
    endtask

    task automatic do_read(input string tag);
        cyc(); chk({tag, " R4 request once ready"}, P_RDREQ);
        cyc(); chk({tag, " R5 request held"}, P_RDREQ);
        mem_wait = 1'b0;
        cyc(); chk({tag, " R3 wait not yet seen"}, P_RDREQ);
        cyc(); chk({tag, " R5 capture"}, P_CAPT);
        mem_wait = 1'b1;
    endtask

    task automatic t_fetch(input logic [1:0] op, input logic sign);
        do_read("fetch");
        cyc(); chk("R6 hold until wait", P_NONE);
        cyc(); chk("R6 mbr to ir", P_TOIR);
        opcode  = op;
        ac_sign = sign;
    endtask

    task automatic t_load();
        cyc(); chk("R7 decode load", P_DECLA);
        do_read("load");
        cyc(); chk("R8 load end", P_LDEND);
    endtask

    task automatic t_add();
        cyc(); chk("R7 decode add", P_DECLA);
        do_read("add");
        cyc(); chk("R9 add end", P_ADEND);
    endtask

    task automatic t_store();
        cyc(); chk("R7 decode store", P_DECST);
        cyc(); chk("R10 write request", P_WRREQ);
        cyc(); chk("R12 write hold rd low", P_WRREQ);
        mem_wait = 1'b0;
        cyc(); chk("R10 write hold", P_WRREQ);
        cyc(); chk("R10 direct fetch", P_FETCH);
        cyc(); chk("R4 idle wait low", P_NONE);
        cyc(); chk("R4 idle wait low", P_NONE);
        mem_wait = 1'b1;
        cyc(); chk("R3 rise not yet seen", P_NONE);
    endtask

    task automatic t_branch(input logic sign);
        cyc(); chk("R11 branch decode", sign ? P_BRT : P_NONE);
        cyc(); chk("R11 branch then fetch", P_FETCH);
    endtask

    task automatic t_midreset();
        cyc(); chk("R4 request", P_RDREQ);
        rst_sync = 1'b1;
        #1; chk("R1 reset mid read", P_CLR);
        cyc(); chk("R1 reset held", P_CLR);
        cyc(); chk("R1 reset held", P_CLR);
        rst_sync = 1'b0;
        #1; chk("R2 release again", P_FETCH);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) cyc();
        chk("R1 reset state", P_CLR);
        rst_sync = 1'b0;
        #1; chk("R2 release", P_FETCH);
        t_fetch(2'b00, 1'b0); t_load();
        t_fetch(2'b10, 1'b0); t_add();
        t_fetch(2'b01, 1'b1); t_store();
        t_fetch(2'b11, 1'b1); t_branch(1'b1);
        t_fetch(2'b11, 1'b0); t_branch(1'b0);
        t_midreset();
        t_fetch(2'b10, 1'b1); t_add();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule